// File: doc/BRIEF.md
# Set/Clear Output Port with Synchronized Input Port

This block is the general-purpose parallel port of a serial controller. It holds an eight-bit output register. Software never writes that register directly. It writes a mask to one address to raise bits, and a mask to a second address to drop bits. A single store therefore changes exactly the bits it names, and no read-modify-write sequence is needed. The output pins are active low, so a bit at 1 pulls its pin low.

A per-bit selection register decides what each output pin shows: the register bit, or an alternate function source. The alternate sources are plain inputs of this block. The selection register is written at the same address that returns the input port on reads.

The input pins are active low. Each pin passes through a two-flop synchronizer, and a read returns the complement of the synchronized level, so an asserted signal reads as 1. Detection of input changes and interrupts are outside this block.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset the output register and the selection register are all zeros, so every output pin is high, and a read of the input address returns the complement of high pins (all zeros).
- R2: A write to address 0xE sets each output register bit whose write-data bit is 1. Bits whose data bit is 0 keep their value. The pins change on the clock edge that takes the write.
- R3: A write to address 0xF clears each output register bit whose write-data bit is 1. Bits whose data bit is 0 keep their value.
- R4: When selection bit i is 0, output pin i drives the complement of output register bit i.
- R5: A write to address 0xD loads the selection register. When selection bit i is 1, output pin i drives the complement of alternate source bit i.
- R6: A read (busRd high) of address 0xD returns, in bits 0 to IN_W-1, the complement of the input pins as sampled two clock edges earlier. Bits at IN_W and above read 0.
- R7: Writes to any address other than 0xE and 0xF leave the output register unchanged. busRdata is 0 whenever busRd is low or the address is not 0xD.
- R8: Set and clear writes update the output register while a bit is routed to its alternate source. The new value appears on the pin once its selection bit returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Register address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read enable |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| altSrc | input | 8 | Alternate function sources, active high |
| inPinN | input | IN_W | Input pins, active low |
| outPinN | output | 8 | Output pins, active low |

## Verification
The hardest situation to reach is a register update that is not visible at the pins. This happens when set and clear writes land on bits that are routed to their alternate sources. The bench routes the upper nibble to a pattern that differs from the register. While the nibble is routed, it sets and clears bits in that nibble, then routes the nibble back and checks that the pending value appears. For the synchronizer, the bench changes the pins and reads in consecutive cycles, so that the two-edge delay shows up in the read data.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DATA_W = 8;

  // Decoded bus strobes passed from control to datapath
  typedef struct packed {
    logic setOut;   // raise masked output bits
    logic clrOut;   // drop masked output bits
    logic selLoad;  // load pin source selection
    logic inSel;    // drive input port onto read data
  } gpioStb_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] SET_ADDR = 4'hE,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 4'hF,
  parameter logic [ADDR_W-1:0] IO_ADDR  = 4'hD
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output gpioStb_t          stb
);
  always_comb begin
    stb.setOut  = busWr && (busAddr == SET_ADDR);
    stb.clrOut  = busWr && (busAddr == CLR_ADDR);
    stb.selLoad = busWr && (busAddr == IO_ADDR);
    stb.inSel   = busRd && (busAddr == IO_ADDR);
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int IN_W        = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpioStb_t          stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] altSrc,
  input  logic [IN_W-1:0]   inPinN,
  output logic [DATA_W-1:0] outPinN,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] outRegQ,
  output logic [DATA_W-1:0] selRegQ
);
  logic [IN_W-1:0] syncQ [SYNC_STAGES];

  // Output register: masked set/clear only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outRegQ <= '0;
    end else if (stb.setOut) begin
      outRegQ <= outRegQ | wdata;
    end else if (stb.clrOut) begin
      outRegQ <= outRegQ & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selRegQ <= '0;
    end else if (stb.selLoad) begin
      selRegQ <= wdata;
    end
  end

  // Input synchronizer chain, reset to the idle (high) pin level
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ[s] <= '1;
      end else if (s == 0) begin
        syncQ[s] <= inPinN;
      end else begin
        syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  end

  // Per-pin source selection, active-low drive
  for (genvar b = 0; b < DATA_W; b++) begin : g_pin
    always_comb begin
      outPinN[b] = selRegQ[b] ? ~altSrc[b] : ~outRegQ[b];
    end
  end

  always_comb begin
    rdata = '0;
    if (stb.inSel) begin
      rdata[IN_W-1:0] = ~syncQ[SYNC_STAGES-1];
    end
  end
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int IN_W   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [7:0]        altSrc,
  input  logic [IN_W-1:0]   inPinN,
  output logic [7:0]        outPinN
);
  gpioStb_t stb;
  logic [DATA_W-1:0] outRegQ;
  logic [DATA_W-1:0] selRegQ;

  gpio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .stb(stb)
  );

  gpio_datapath #(.IN_W(IN_W), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .altSrc(altSrc), .inPinN(inPinN), .outPinN(outPinN),
    .rdata(busRdata), .outRegQ(outRegQ), .selRegQ(selRegQ)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int ADDR_W = 4,
  parameter int IN_W   = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic [7:0]        altSrc,
  input logic [7:0]        outPinN,
  input logic [7:0]        outRegQ,
  input logic [7:0]        selRegQ
);
  localparam logic [7:0] IN_MASK = 8'((1 << IN_W) - 1);
  logic isSet, isClr;
  assign isSet = busWr && (busAddr == ADDR_W'(4'hE));
  assign isClr = busWr && (busAddr == ADDR_W'(4'hF));

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    isSet |=> (outRegQ == ($past(outRegQ) | $past(busWdata))));

  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    isClr |=> (outRegQ == ($past(outRegQ) & ~$past(busWdata))));

  p_pin_reg_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((outPinN ^ ~outRegQ) & ~selRegQ) == 8'h00);

  p_pin_alt_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((outPinN ^ ~altSrc) & selRegQ) == 8'h00);

  p_rd_upper_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata & ~IN_MASK) == 8'h00);

  p_hold_reg_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(isSet || isClr) |=> $stable(outRegQ));

  p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdata == 8'h00));
endmodule

bind gpio_setclr_port gpio_port_chk #(.ADDR_W(ADDR_W), .IN_W(IN_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWdata(busWdata), .busRdata(busRdata), .altSrc(altSrc),
  .outPinN(outPinN), .outRegQ(outRegQ), .selRegQ(selRegQ)
);

// File: tb/gpio_setclr_port_tb.sv
`timescale 1ns/1ps
module gpio_setclr_port_tb;
  localparam int IN_W = 7;

  logic clk = 0;
  logic rstN = 0;
  logic [3:0] busAddr = 4'h0;
  logic busWr = 0, busRd = 0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [7:0] altSrc = 8'h00;
  logic [IN_W-1:0] inPinN = '1;
  logic [7:0] outPinN;

  int checks = 0, failures = 0;
  string curReq = "R1";

  // Reference model state
  logic [7:0] mReg = 8'h00, mSel = 8'h00;
  logic [IN_W-1:0] mS1 = '1, mS2 = '1;

  always #5 clk = ~clk;

  gpio_setclr_port #(.ADDR_W(4), .IN_W(IN_W)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .altSrc(altSrc),
    .inPinN(inPinN), .outPinN(outPinN)
  );

  function automatic logic [7:0] expPins();
    return ~((mSel & altSrc) | (~mSel & mReg));
  endfunction

  function automatic logic [7:0] expRd();
    logic [7:0] v = 8'h00;
    if (busRd && busAddr == 4'hD) v[IN_W-1:0] = ~mS2;
    return v;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model, updated on each clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      mReg = 8'h00; mSel = 8'h00; mS1 = '1; mS2 = '1;
    end else begin
      mS2 = mS1;
      mS1 = inPinN;
      if (busWr && busAddr == 4'hE) mReg = mReg | busWdata;
      else if (busWr && busAddr == 4'hF) mReg = mReg & ~busWdata;
      else if (busWr && busAddr == 4'hD) mSel = busWdata;
    end
  end

  // Per-clock comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      chk(curReq, outPinN, expPins());
      chk((curReq == "R7") ? "R7" : "R6", busRdata, expRd());
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk); busWr = 0; busWdata = 8'h00;
  endtask

  task automatic rdChk(string req, logic [3:0] a, logic [7:0] exp);
    @(negedge clk); busAddr = a; busRd = 1;
    #1 chk(req, busRdata, exp);
    @(negedge clk); busRd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", outPinN, 8'hFF);
    rdChk("R1", 4'hD, 8'h00);

    // R2: masked set
    curReq = "R2";
    wr(4'hE, 8'h05); chk("R2", outPinN, 8'hFA);
    wr(4'hE, 8'h30); chk("R2", outPinN, 8'hCA);
    wr(4'hE, 8'h00); chk("R2", outPinN, 8'hCA);

    // R3: masked clear
    curReq = "R3";
    wr(4'hF, 8'h14); chk("R3", outPinN, 8'hDE);
    wr(4'hF, 8'h00); chk("R3", outPinN, 8'hDE);

    // R4: all pins from register
    curReq = "R4";
    wr(4'hE, 8'hFF); chk("R4", outPinN, 8'h00);
    wr(4'hF, 8'hDE); chk("R4", outPinN, 8'hDE);

    // R7: other addresses have no effect
    curReq = "R7";
    wr(4'h0, 8'hFF); wr(4'h4, 8'hFF); wr(4'h3, 8'h00); wr(4'hD, 8'h00);
    chk("R7", outPinN, 8'hDE);
    rdChk("R7", 4'hE, 8'h00);
    rdChk("R7", 4'h4, 8'h00);

    // R6: synchronized, inverted input port
    curReq = "R6";
    @(negedge clk); inPinN = 7'h55;
    repeat (3) @(negedge clk);
    rdChk("R6", 4'hD, 8'h2A);
    @(negedge clk); inPinN = 7'h00; busAddr = 4'hD; busRd = 1;
    #1 chk("R6", busRdata, 8'h2A);
    @(negedge clk); #1 chk("R6", busRdata, 8'h2A);
    @(negedge clk); #1 chk("R6", busRdata, 8'h7F);
    busRd = 0;
    @(negedge clk); inPinN = '1;
    repeat (3) @(negedge clk);

    // R5: alternate sources on upper nibble
    curReq = "R5";
    @(negedge clk); altSrc = 8'hA5;
    wr(4'hD, 8'hF0); chk("R5", outPinN, 8'h5E);
    @(negedge clk); altSrc = 8'h3C;
    @(negedge clk); chk("R5", outPinN, 8'hCE);

    // R8: register updates while routed elsewhere
    curReq = "R8";
    wr(4'hE, 8'hC0); chk("R8", outPinN, 8'hCE);
    wr(4'hF, 8'h20); chk("R8", outPinN, 8'hCE);
    wr(4'hD, 8'h00); chk("R8", outPinN, 8'h3E);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule